// File: doc/BRIEF.md
# BCH Error-Location Bit Corrector

This block finishes the correction of one data sector after a BCH decoder has found where the bit errors are. It takes the decoder's status image as input. That image is one status word plus a set of packed position words. The block then repairs the sector in a byte-wide buffer, one bit at a time. A single-cycle start pulse captures the whole image. The block then walks the listed error positions in order, up to the error count given in the status word.

For each position that lies inside the sector's data bits, the block reads the byte that holds the bit. It inverts that one bit and writes the byte back. A position that lies beyond the data, in the parity bytes, is passed over silently. When the walk ends, the block raises done with a two-bit status: clean, corrected or uncorrectable. Done and the status stay up until the next accepted start.

Top module: `bch_bitfix`

## Requirements
- R1: After reset, done and busy are low and the buffer port is idle: no read strobe and no write strobe.
- R2: If the error-found flag (status word bit 1) is 0 at start, the block is done in the next cycle with status 2'b01 (clean). It makes no buffer access.
- R3: If the error-found flag is 1 and the uncorrectable flag (status word bit 0) is 1, the block is done in the next cycle with status 2'b11 (uncorrectable). It makes no buffer access.
- R4: Only the first N positions are processed, where N is the count field in status word bits 7:4. When N is 0 and errors are flagged, the block finishes as corrected without touching the buffer.
- R5: A count field larger than the maximum list length (8) is treated as 8.
- R6: A position at or above SECTOR_BYTES*8 is skipped in one busy cycle. During that cycle there is no read strobe and no write strobe.
- R7: An accepted position p costs two cycles. In the first cycle the block reads address p>>3. In the second cycle it writes the same address with the data that was read, with bit p[2:0] inverted. Read data arrives one cycle after the read strobe.
- R8: Position k+1 (k from 0) is taken from position word k/2, starting at bit 0 of that word when k is even and at bit 16 when k is odd. Each position is 13 bits wide. Positions are processed in increasing k.
- R9: After the last position, done rises with status 2'b10 (corrected) and busy falls. Done and the status hold steady until a new start.
- R10: A start pulse that arrives while busy is ignored.
- R11: The status and position inputs are sampled only in the start cycle. Later changes to them have no effect on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures the status image |
| stat_i | input | 32 | Status word: bit 0 uncorrectable, bit 1 errors found, bits 7:4 count |
| pos_words_i | input | 128 | Four position words, two 13-bit positions in each |
| buf_addr_o | output | 9 | Byte address in the sector buffer |
| buf_rd_o | output | 1 | Buffer read strobe |
| buf_wr_o | output | 1 | Buffer write strobe |
| buf_wdata_o | output | 8 | Corrected byte to write |
| buf_rdata_i | input | 8 | Byte read, valid one cycle after the read strobe |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Result valid, held until the next start |
| status_o | output | 2 | 01 clean, 10 corrected, 11 uncorrectable |

## Verification
The assertions check the buffer-port discipline on every cycle. Each write must follow a read of the same address one cycle earlier, and the two strobes are never high together. The port must stay quiet whenever the block is not busy, and done and the status must hold steady while no start arrives. Other behaviours can be shown only by the bench's scenarios, against its behavioural model. These are:
- which positions are selected and how many;
- the count saturation;
- the parity-area filter at exactly SECTOR_BYTES*8;
- the bit that gets inverted;
- two errors in one byte;
- a start that arrives while busy;
- inputs that change after sampling.

// File: rtl/bch_bitfix_pkg.sv
package bch_bitfix_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_FIX  = 2'd2,
        ST_DONE = 2'd3
    } fix_state_e;

    localparam logic [1:0] RES_NONE    = 2'b00;
    localparam logic [1:0] RES_CLEAN   = 2'b01;
    localparam logic [1:0] RES_FIXED   = 2'b10;
    localparam logic [1:0] RES_UNCORR  = 2'b11;

    localparam int UNCORR_BIT = 0;
    localparam int FOUND_BIT  = 1;
    localparam int CNT_LSB    = 4;
    localparam int CNT_W      = 4;

    localparam int WORD_W     = 32;
    localparam int HI_LSB     = 16;

endpackage

// File: rtl/bch_pos_unpack.sv
module bch_pos_unpack #(
    parameter int MAX_ERR = 8,
    parameter int POS_W   = 13
) (
    input  logic [(MAX_ERR/2)*32-1:0] words_i,
    output logic [MAX_ERR*POS_W-1:0]  pos_o
);
    import bch_bitfix_pkg::*;

    localparam int WORDS = MAX_ERR / 2;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WORD_W-1:0] word;
        logic              unused_hi;
        assign word = words_i[w*WORD_W +: WORD_W];
        assign pos_o[(2*w)*POS_W +: POS_W]   = word[0 +: POS_W];
        assign pos_o[(2*w+1)*POS_W +: POS_W] = word[HI_LSB +: POS_W];
        assign unused_hi = ^{word[HI_LSB-1:POS_W], word[WORD_W-1:HI_LSB+POS_W]};
    end

endmodule

// File: rtl/bch_pos_check.sv
module bch_pos_check #(
    parameter int SECTOR_BYTES = 512,
    parameter int POS_W        = 13,
    localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
    input  logic [POS_W-1:0]  pos_i,
    output logic              in_data_o,
    output logic [ADDR_W-1:0] byte_o,
    output logic [7:0]        mask_o
);
    localparam int BIT_LIMIT = SECTOR_BYTES * 8;

    assign in_data_o = 32'(pos_i) < 32'(BIT_LIMIT);
    assign byte_o    = pos_i[3 +: ADDR_W];
    assign mask_o    = 8'b1 << pos_i[2:0];

endmodule

// File: rtl/bch_bitfix.sv
module bch_bitfix #(
    parameter int SECTOR_BYTES = 512,
    parameter int MAX_ERR      = 8,
    parameter int POS_W        = 13,
    localparam int ADDR_W      = $clog2(SECTOR_BYTES),
    localparam int WORDS       = MAX_ERR / 2,
    localparam int IDX_W       = $clog2(MAX_ERR)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [31:0]           stat_i,
    input  logic [WORDS*32-1:0]   pos_words_i,
    output logic [ADDR_W-1:0]     buf_addr_o,
    output logic                  buf_rd_o,
    output logic                  buf_wr_o,
    output logic [7:0]            buf_wdata_o,
    input  logic [7:0]            buf_rdata_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [1:0]            status_o
);
    import bch_bitfix_pkg::*;

    typedef struct packed {
        fix_state_e             st;
        logic [IDX_W-1:0]       idx;
        logic [IDX_W-1:0]       last;
        logic [1:0]             res;
        logic [WORDS*32-1:0]    words;
    } regs_t;

    regs_t q, d;

    // Positions from the captured image
    logic [MAX_ERR*POS_W-1:0] pos_flat;
    logic [POS_W-1:0]         pos_cur;
    logic                     pos_ok;
    logic [ADDR_W-1:0]        pos_byte;
    logic [7:0]               pos_mask;

    bch_pos_unpack #(.MAX_ERR(MAX_ERR), .POS_W(POS_W)) u_unpack (
        .words_i (q.words),
        .pos_o   (pos_flat)
    );

    assign pos_cur = pos_flat[q.idx*POS_W +: POS_W];

    bch_pos_check #(.SECTOR_BYTES(SECTOR_BYTES), .POS_W(POS_W)) u_check (
        .pos_i     (pos_cur),
        .in_data_o (pos_ok),
        .byte_o    (pos_byte),
        .mask_o    (pos_mask)
    );

    // Status-word decode with count saturation
    logic             st_found;
    logic             st_uncorr;
    logic [CNT_W-1:0] st_cnt;
    logic [31:0]      cnt_eff;
    logic             unused_stat;

    assign st_found    = stat_i[FOUND_BIT];
    assign st_uncorr   = stat_i[UNCORR_BIT];
    assign st_cnt      = stat_i[CNT_LSB +: CNT_W];
    assign cnt_eff     = (32'(st_cnt) > 32'(MAX_ERR)) ? 32'(MAX_ERR) : 32'(st_cnt);
    assign unused_stat = ^{stat_i[31:CNT_LSB+CNT_W], stat_i[CNT_LSB-1:FOUND_BIT+1]};

    logic rd_c, wr_c;
    logic at_last;
    assign at_last = (q.idx == q.last);

    always_comb begin
        d    = q;
        rd_c = 1'b0;
        wr_c = 1'b0;
        unique case (q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    d.words = pos_words_i;
                    d.idx   = '0;
                    if (!st_found) begin
                        d.st  = ST_DONE;
                        d.res = RES_CLEAN;
                    end else if (st_uncorr) begin
                        d.st  = ST_DONE;
                        d.res = RES_UNCORR;
                    end else if (cnt_eff == 32'd0) begin
                        d.st  = ST_DONE;
                        d.res = RES_FIXED;
                    end else begin
                        d.st   = ST_WALK;
                        d.res  = RES_NONE;
                        d.last = IDX_W'(cnt_eff - 32'd1);
                    end
                end
            end
            ST_WALK: begin
                if (pos_ok) begin
                    rd_c = 1'b1;
                    d.st = ST_FIX;
                end else if (at_last) begin
                    d.st  = ST_DONE;
                    d.res = RES_FIXED;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_FIX: begin
                wr_c = 1'b1;
                if (at_last) begin
                    d.st  = ST_DONE;
                    d.res = RES_FIXED;
                end else begin
                    d.idx = q.idx + 1'b1;
                    d.st  = ST_WALK;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.idx   <= '0;
            q.last  <= '0;
            q.res   <= RES_NONE;
            q.words <= '0;
        end else begin
            q <= d;
        end
    end

    assign buf_addr_o  = pos_byte;
    assign buf_rd_o    = rd_c;
    assign buf_wr_o    = wr_c;
    assign buf_wdata_o = buf_rdata_i ^ pos_mask;
    assign busy_o      = (q.st == ST_WALK) || (q.st == ST_FIX);
    assign done_o      = (q.st == ST_DONE);
    assign status_o    = q.res;

    // Buffer-port discipline
    p_wr_after_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_o |=> buf_wr_o);
    p_wr_has_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_o |-> $past(buf_rd_o));
    p_wr_same_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_o |-> buf_addr_o == $past(buf_addr_o));
    p_port_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_o && buf_wr_o));
    // No access outside a walk (R2, R3)
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !buf_rd_o && !buf_wr_o);
    // Result held until next start
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i |=> done_o && $stable(status_o));
    p_done_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> status_o != RES_NONE && !busy_o);

endmodule

// File: tb/sim_bch_bitfix.sv
`timescale 1ns/1ps
module sim_bch_bitfix;

    localparam int SB = 512;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [31:0]  stat = '0;
    logic [127:0] pw = '0;
    logic [8:0]   addr;
    logic         rd, wr;
    logic [7:0]   wdata;
    logic [7:0]   rdata;
    logic         busy, done;
    logic [1:0]   status;

    always #2.5 clk = ~clk;

    bch_bitfix u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .stat_i(stat),
        .pos_words_i(pw), .buf_addr_o(addr), .buf_rd_o(rd), .buf_wr_o(wr),
        .buf_wdata_o(wdata), .buf_rdata_i(rdata), .busy_o(busy),
        .done_o(done), .status_o(status)
    );

    // Sector buffer, read data registered
    logic [7:0] ram [SB];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SB; i++) ram[i] <= 8'((i * 37 + 5) & 255);
            rdata <= '0;
        end else begin
            if (wr) ram[addr] <= wdata;
            if (rd) rdata <= ram[addr];
        end
    end

    // Reference model
    typedef struct { int kind; int a; int dat; } rec_t; // 0 skip, 1 read, 2 write
    rec_t q[$];
    int   model [SB];
    int   exp_done = 0;
    int   exp_stat = 0;
    bit   cur_busy = 0;
    string tag = "R1";
    int   total = 0;
    int   bad = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string t, input string what, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", t, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (q.size() > 0) begin
                rec_t r;
                r = q.pop_front();
                cur_busy = 1;
                if (r.kind == 0) begin
                    check(busy && !done && !rd && !wr, {tag, " R6 skip"}, "busy/done/rd/wr",
                          {busy, done, rd, wr}, 4'b1000);
                end else if (r.kind == 1) begin
                    check(busy && rd && !wr && addr == 9'(r.a), {tag, " R7 read"}, "rd/wr/addr",
                          {rd, wr, 3'b0, addr}, {1'b1, 1'b0, 3'b0, 9'(r.a)});
                end else begin
                    check(busy && wr && !rd && addr == 9'(r.a) && wdata == 8'(r.dat),
                          {tag, " R7 write"}, "wr/addr/wdata",
                          {wr, 3'b0, addr, wdata}, {1'b1, 3'b0, 9'(r.a), 8'(r.dat)});
                end
            end else begin
                cur_busy = 0;
                check(!busy && !rd && !wr && done == exp_done[0] &&
                      (!exp_done[0] || status == exp_stat[1:0]),
                      {tag, " R9 idle/hold"}, "busy/rd/wr/done/status",
                      {busy, rd, wr, done, status}, {3'b000, exp_done[0], exp_stat[1:0]});
            end
        end
    end

    function automatic logic [31:0] mkw(input int p1, input int p2);
        return {3'b000, 13'(p2), 3'b000, 13'(p1)};
    endfunction

    task automatic launch(input logic [31:0] s0, input logic [127:0] p, input string t);
        bit accept;
        @(posedge clk); #1;
        stat = s0; pw = p; start = 1'b1;
        accept = !cur_busy;
        @(posedge clk); #1;
        start = 1'b0;
        // R11: scramble inputs after sampling
        stat = 32'h5A5A_5AF2; pw = {4{32'h0ABC_0123}};
        if (!accept) return;
        tag = t;
        if (!s0[1]) exp_stat = 1;
        else if (s0[0]) exp_stat = 3;
        else begin
            int n;
            n = (int'(s0[7:4]) > 8) ? 8 : int'(s0[7:4]);
            for (int k = 0; k < n; k++) begin
                int pos;
                pos = (k % 2 == 0) ? int'(p[32*(k/2) +: 13]) : int'(p[32*(k/2) + 16 +: 13]);
                if (pos < SB * 8) begin
                    int a, v;
                    a = pos / 8;
                    v = model[a] ^ (1 << (pos % 8));
                    q.push_back('{1, a, 0});
                    q.push_back('{2, a, v});
                    model[a] = v;
                end else begin
                    q.push_back('{0, 0, 0});
                end
            end
            exp_stat = 2;
        end
        exp_done = 1;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while ((q.size() > 0 || cur_busy) && n < 500) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < SB; i++) model[i] = (i * 37 + 5) & 255;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!done && !busy && !rd && !wr, "R1", "reset outputs", {done, busy, rd, wr}, 0);
        repeat (2) @(negedge clk);

        // R2: nothing found
        launch(32'h0000_0030, {mkw(1, 2), mkw(3, 4), mkw(5, 6), mkw(7, 8)}, "R2");
        wait_idle();
        // R3: uncorrectable
        launch(32'h0000_0033, {mkw(1, 2), mkw(3, 4), mkw(5, 6), mkw(7, 8)}, "R3");
        wait_idle();
        // R8: four positions, order and field placement
        launch(32'h0000_0042, {mkw(0, 0), mkw(0, 0), mkw(2345, 3000), mkw(10, 1000)}, "R8");
        wait_idle();
        // R4: count 2 of eight listed
        launch(32'h0000_0022, {mkw(400, 401), mkw(402, 403), mkw(404, 405), mkw(406, 407)}, "R4");
        wait_idle();
        // R4: count 0 with errors flagged
        launch(32'h0000_0002, {mkw(50, 51), mkw(52, 53), mkw(54, 55), mkw(56, 57)}, "R4 zero");
        wait_idle();
        // R5: count 15 saturates to 8
        launch(32'h0000_00F2, {mkw(700, 1701), mkw(2702, 3703), mkw(8, 9), mkw(4000, 17)}, "R5");
        wait_idle();
        // R6: parity boundary
        launch(32'h0000_0042, {mkw(0, 0), mkw(0, 0), mkw(8191, 0), mkw(4095, 4096)}, "R6");
        wait_idle();
        // R7: two errors in one byte
        launch(32'h0000_0032, {mkw(0, 0), mkw(0, 0), mkw(100, 0), mkw(100, 101)}, "R7");
        wait_idle();
        // R10: start while busy is ignored
        launch(32'h0000_0082, {mkw(1200, 1201), mkw(1300, 1301), mkw(1400, 1401), mkw(1500, 1501)}, "R10");
        repeat (3) @(negedge clk);
        launch(32'h0000_0012, {mkw(9, 9), mkw(9, 9), mkw(9, 9), mkw(9, 9)}, "R10 ignored");
        wait_idle();
        // R11: inputs changed right after start (scrambled by launch)
        launch(32'h0000_0022, {mkw(0, 0), mkw(0, 0), mkw(0, 0), mkw(33, 4090)}, "R11");
        wait_idle();
        // R2 again after a corrected run: status replaced
        launch(32'h0000_0000, 128'h0, "R2 restart");
        wait_idle();

        for (int i = 0; i < SB; i++)
            check(int'(ram[i]) == model[i], "R7 buffer image", "byte", int'(ram[i]), model[i]);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule